// File: doc/BRIEF.md
# Compare-Driven PWM Timer

This block generates a pulse-width-modulated waveform from a 16-bit up-counter. A power-of-two prescaler divides the base clock into count ticks, and the counter advances once per tick. Two compare values shape the waveform. The period value closes each cycle: the counter goes back to zero on the tick after it reaches that value. The duty value ends the active phase. A set/reset latch is set by the period match and cleared by the duty match. A polarity bit then maps the latch state to the pin level.

Software stops the timer and loads the period, duty and polarity through one-cycle write strobes that share a data bus. It then raises the enable. While the timer runs, all three writes are dropped. A small state machine follows the run. It moves from IDLE to ARMED when enable rises. It moves from ARMED to RUN on the first period match. It goes back to IDLE from either state as soon as enable falls. Because of this, the first cycle after enable always shows the inactive level. Each compare match also gives a one-base-clock interrupt pulse.

Top module: `pwm_timer`

## Requirements
- R1: After reset, pwm_out, per_irq and duty_irq are all 0. Polarity resets to 0, the period to all ones and the duty to zero.
- R2: clk_sel value s gives one count tick every 2^(s+1) base clocks for s from 0 to 6. The value 7 behaves like 6 (divide by 128).
- R3: The counter starts at 0 on enable and rises by one per tick. On the tick where it reaches the period value, per_irq is high for exactly one base clock.
- R4: On the tick after a period match, the counter goes to 0. For a period value P of 1 or more, each cycle is therefore P+1 ticks long.
- R5: On the tick where the counter reaches the duty value, duty_irq is high for exactly one base clock. With a duty of 0 this first happens after the first wrap.
- R6: The latch is set by a period match and cleared by a duty match. For a duty D below P, it is active for the counts P, 0, 1, …, D-1. The pin follows the latch one base clock after the interrupt pulse.
- R7: If D equals P, both matches land on the same tick and the clear wins, so the output never goes active. If D is above P, the output stays active after the first period match.
- R8: From enable until the first period match (ARMED state), pwm_out stays at the inactive level.
- R9: The polarity bit is loaded from wr_data[0] with pol_wr. With 0 the active level is 1; with 1 the active level is 0 and the inactive level is 1. A pol_wr while en is 1 has no effect.
- R10: per_wr and duty_wr load wr_data only while en is 0. Strobes while en is 1 leave the running waveform unchanged.
- R11: When en falls, the state returns to IDLE, the counter and prescaler clear, and pwm_out takes the inactive level after the next clock. Enabling again restarts from the ARMED state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| clk_sel | input | 3 | Prescaler select, divide by 2^(clk_sel+1), capped at 128 |
| per_wr | input | 1 | Period write strobe |
| duty_wr | input | 1 | Duty write strobe |
| pol_wr | input | 1 | Polarity write strobe (uses wr_data[0]) |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM waveform |
| per_irq | output | 1 | Period-match pulse |
| duty_irq | output | 1 | Duty-match pulse |

## Verification
A wrong prescaler or counter state shows up within one cycle as per_irq or duty_irq pulses at the wrong base-clock positions. It also shows up one clock later as pwm_out edges that no longer fit the P+1 tick cycle. A latch or state-machine fault shows up at the first period match: the output becomes active too early, stays inactive, or ignores the clear-wins rule. A polarity or write-gating fault inverts or shifts the waveform at the next enable. A missed return to IDLE leaves pwm_out active one clock after en falls.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_state_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W  = MAX_SEL + 1;
    localparam int FULL_W = DIV_W + 1;

    logic [SEL_W-1:0]  sel_eff;
    logic [FULL_W-1:0] span;
    logic [DIV_W-1:0]  div_last;
    logic [DIV_W-1:0]  pre_cnt;

    always_comb begin
        sel_eff  = (int'(sel) > MAX_SEL) ? SEL_W'(MAX_SEL) : sel;
        span     = FULL_W'(2) << sel_eff;
        div_last = DIV_W'(span - FULL_W'(1));
    end

    assign tick = run && (pre_cnt >= div_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!run || tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + DIV_W'(1);
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             per_hit,
    output logic             duty_hit
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             clr_pend;

    assign cnt_nxt = clr_pend ? '0 : cnt + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            clr_pend <= 1'b0;
            per_hit  <= 1'b0;
            duty_hit <= 1'b0;
        end else if (!run) begin
            cnt      <= '0;
            clr_pend <= 1'b0;
            per_hit  <= 1'b0;
            duty_hit <= 1'b0;
        end else begin
            per_hit  <= 1'b0;
            duty_hit <= 1'b0;
            if (tick) begin
                cnt      <= cnt_nxt;
                clr_pend <= (cnt_nxt == period);
                per_hit  <= (cnt_nxt == period);
                duty_hit <= (cnt_nxt == duty);
            end
        end
    end

    // R4
    clr_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && clr_pend) |=> (cnt == '0));

    // R3
    per_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_hit |=> !per_hit);

    // R5
    duty_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_hit |=> !duty_hit);
endmodule

// File: rtl/pwm_outctl.sv
module pwm_outctl
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic per_hit,
    input  logic duty_hit,
    input  logic polarity,
    output logic pwm_out
);
    run_state_e state_q, state_d;
    logic       set_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!run)         state_d = ST_IDLE;
                else if (per_hit) state_d = ST_RUN;
            end
            ST_RUN:   if (!run) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q <= 1'b0;
        end else if (!run || state_q == ST_IDLE) begin
            set_q <= 1'b0;
        end else if (duty_hit) begin
            set_q <= 1'b0;
        end else if (per_hit) begin
            set_q <= 1'b1;
        end
    end

    assign pwm_out = set_q ^ polarity;

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !set_q);

    // R7
    reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per_hit && duty_hit) |=> !set_q);

    // R8
    armed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> !set_q);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
    parameter int CNT_W   = 16,
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             per_wr,
    input  logic             duty_wr,
    input  logic             pol_wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             per_irq,
    output logic             duty_irq
);
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] duty_q;
    logic             pol_q;
    logic             tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '1;
            duty_q   <= '0;
            pol_q    <= 1'b0;
        end else if (!en) begin
            if (per_wr)  period_q <= wr_data;
            if (duty_wr) duty_q   <= wr_data;
            if (pol_wr)  pol_q    <= wr_data[0];
        end
    end

    pwm_prescaler #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) presc_i (
        .clk(clk), .rst_n(rst_n), .run(en), .sel(clk_sel), .tick(tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) count_i (
        .clk(clk), .rst_n(rst_n), .run(en), .tick(tick),
        .period(period_q), .duty(duty_q),
        .per_hit(per_irq), .duty_hit(duty_irq)
    );

    pwm_outctl outctl_i (
        .clk(clk), .rst_n(rst_n), .run(en), .per_hit(per_irq),
        .duty_hit(duty_irq), .polarity(pol_q), .pwm_out(pwm_out)
    );

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> ($stable(period_q) && $stable(duty_q)));

    // R9
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(pol_q));
endmodule

// File: tb/pwm_timer_tb_top.sv
module pwm_timer_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [2:0]  clk_sel = 3'd0;
    logic        per_wr = 1'b0, duty_wr = 1'b0, pol_wr = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_out, per_irq, duty_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic cur_pol = 1'b0;

    // fields: [35:33] select, [32:17] period, [16:1] duty, [0] polarity
    localparam logic [35:0] VEC [7] = '{
        {3'd0, 16'd3, 16'd1, 1'b0},
        {3'd1, 16'd4, 16'd2, 1'b1},
        {3'd0, 16'd2, 16'd2, 1'b0},
        {3'd2, 16'd3, 16'd5, 1'b0},
        {3'd0, 16'd5, 16'd0, 1'b0},
        {3'd7, 16'd1, 16'd0, 1'b1},
        {3'd6, 16'd2, 16'd1, 1'b0}
    };

    always #(CLK_P/2) clk = ~clk;

    pwm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .clk_sel(clk_sel),
        .per_wr(per_wr), .duty_wr(duty_wr), .pol_wr(pol_wr),
        .wr_data(wr_data), .pwm_out(pwm_out), .per_irq(per_irq),
        .duty_irq(duty_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R6";
            1: return "R9";
            2: return "R7";
            3: return "R7";
            4: return "R5";
            default: return "R2";
        endcase
    endfunction

    function automatic bit active(input int t, input int p, input int d);
        int c;
        c = t % (p + 1);
        if (t < p) return 1'b0;
        if (d > p) return 1'b1;
        if (d == p) return 1'b0;
        return (c == p) || (c < d);
    endfunction

    task automatic wr(input int kind, input logic [15:0] d);
        wr_data = d;
        per_wr  = (kind == 0);
        duty_wr = (kind == 1);
        pol_wr  = (kind == 2);
        @(negedge clk);
        per_wr = 1'b0; duty_wr = 1'b0; pol_wr = 1'b0;
    endtask

    task automatic run_vec(input int sel, input int p, input int d, input bit pol,
                           input bit poke, input string tag);
        int div, ncyc, t, t2;
        en = 1'b0;
        @(negedge clk);
        // R11: stopped timer drives the inactive level, no pulses
        check("R11", pwm_out, cur_pol);
        check("R11", per_irq, 1'b0);
        check("R11", duty_irq, 1'b0);
        clk_sel = 3'(sel);
        wr(0, 16'(p));
        wr(1, 16'(d));
        wr(2, {15'd0, pol});
        cur_pol = pol;
        // R9: new polarity sets the idle level
        check("R9", pwm_out, pol);
        en = 1'b1;
        div = 2 << ((sel > 6) ? 6 : sel);
        ncyc = 3 * (p + 1) * div + div;
        for (int e = 1; e <= ncyc; e++) begin
            if (poke && e == 3) begin
                wr_data = {15'h0004, ~pol};
                per_wr = 1'b1; duty_wr = 1'b1; pol_wr = 1'b1;
            end
            @(negedge clk);
            per_wr = 1'b0; duty_wr = 1'b0; pol_wr = 1'b0;
            t  = e / div;
            t2 = (e - 1) / div;
            check((t <= p) ? "R3" : "R4", per_irq,
                  (e % div == 0) && (t % (p + 1) == p));
            check("R5", duty_irq,
                  (e % div == 0) && (t % (p + 1) == d));
            check((t2 < p) ? "R8" : tag, pwm_out, active(t2, p, d) ^ pol);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", pwm_out, 1'b0);
        check("R1", per_irq, 1'b0);
        check("R1", duty_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", pwm_out, 1'b0);
        check("R1", per_irq, 1'b0);

        for (int i = 0; i < 7; i++) begin
            run_vec(int'(VEC[i][35:33]), int'(VEC[i][32:17]), int'(VEC[i][16:1]),
                    VEC[i][0], 1'b0, vec_tag(i));
        end

        // R10 and R9: writes while running must leave the waveform intact
        run_vec(0, 3, 1, 1'b0, 1'b1, "R10");
        run_vec(1, 2, 1, 1'b1, 1'b1, "R10");

        // R11: stop mid-run, output falls to inactive after one clock
        en = 1'b0;
        @(negedge clk);
        check("R11", pwm_out, cur_pol);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R11", per_irq, 1'b0);
            check("R11", pwm_out, cur_pol);
        end
        // R11: re-enable restarts from the first cycle
        run_vec(0, 3, 1, 1'b0, 1'b0, "R11");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule